// File: doc/BRIEF.md
# Low-Side Load Fault Supervisor

This block watches a group of low-side output channels and the battery supply that feeds them, using only digital comparator results. Each channel has a gate enable from the controller and a comparator that says whether its drain sits above the reference threshold. While a gate is off, a drain that stays low means the load is open. While a gate is on, a drain that stays high means the load is shorted. A channel judges its comparator only after its gate has been stable for a settling delay, which is a parameter in clock cycles.

Detected faults are latched into a fault vector that a serial block can snapshot. The vector holds one bit per channel and two battery bits. An active-low interrupt is low whenever any latched bit is set. A falling edge on chip select reloads the latched bits from the conditions present at that moment, so a fault that has cleared stops holding the interrupt.

A parameter picks how a shorted channel is protected. In latch-off mode the gate is held off until its command is toggled. In retry mode the gate is pulsed at a low duty cycle for as long as the command stays on. A battery over-voltage or under-voltage input forces every gate off and suspends all channel tests.

Top module: `load_fault_supervisor`

## Requirements
- R1: Out of reset every gate is 0, fault_vec is all zeros and flt_n is 1.
- R2: With no fault active, gate[i] equals cmd_en[i] from the previous clock.
- R3: Open-load: when gate[i] has held 0 for SETTLE_CYCLES clocks and drain_hi[i] is 0, fault_vec[i] is set on the next clock. The bit is never set before the settle count has elapsed since the last gate change.
- R4: Short-load: when gate[i] has held 1 for SETTLE_CYCLES clocks and drain_hi[i] is 1, fault_vec[i] is set on the next clock.
- R5: The bit order of fault_vec is: bit NCH+1 = battery over-voltage, bit NCH = battery under-voltage, bits NCH-1..0 = channels. flt_n is 0 exactly when any bit of fault_vec is 1.
- R6: Latched bits stay set without a chip-select falling edge. On a falling edge of cs_n, each bit is reloaded with its present condition. A channel's condition includes an active short protection, and a battery bit's condition is its input level.
- R7: Latch-off mode (LATCH_OFF=1): after a short is detected, the gate is held at 0 until cmd_en[i] goes low and then high again.
- R8: Retry mode (LATCH_OFF=0): while the short protection is active and cmd_en[i] stays 1, the gate is 1 for RETRY_ON clocks in every RETRY_PERIOD clocks. The protection ends when cmd_en[i] goes low.
- R9: While bat_over or bat_under is 1, every gate is 0 from the next clock. The matching fault_vec bit is set on the next clock.
- R10: While a battery input is active, no channel open-load or short-load bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_en | input | NCH | Gate enable command per channel |
| drain_hi | input | NCH | Drain-above-reference comparator per channel |
| bat_over | input | 1 | Battery over-voltage comparator |
| bat_under | input | 1 | Battery under-voltage comparator |
| cs_n | input | 1 | Chip select; its falling edge reloads the latched faults |
| gate | output | NCH | Gate drive per channel |
| flt_n | output | 1 | Active-low fault interrupt |
| fault_vec | output | NCH+2 | Latched faults: over, under, channels NCH-1..0 |

## Verification
The hardest situation to reach is a channel test that must not fire. An open load has to be ignored while a battery fault holds the gates off. It also has to be ignored while a retry pulse keeps restarting the settle timer. The stimulus holds a commanded channel's drain low through a long battery fault and checks that the channel bits stay clear. It then drives a shorted channel in retry mode for two full retry periods and counts the on-clocks at the gate. A second instance in latch-off mode runs on the same inputs. On that instance the command is toggled with the drain released at the same clock, so the recovered gate does not raise a false short.

// File: rtl/load_fault_supervisor.sv
module load_fault_supervisor #(
  parameter int NCH           = 6,
  parameter int SETTLE_CYCLES = 6000000,
  parameter int RETRY_PERIOD  = 16,
  parameter int RETRY_ON      = 1,
  parameter bit LATCH_OFF     = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cmd_en,
  input  logic [NCH-1:0] drain_hi,
  input  logic           bat_over,
  input  logic           bat_under,
  input  logic           cs_n,
  output logic [NCH-1:0] gate,
  output logic           flt_n,
  output logic [NCH+1:0] fault_vec
);
  localparam int TW = $clog2(SETTLE_CYCLES + 1);
  localparam int PW = (RETRY_PERIOD > 2) ? $clog2(RETRY_PERIOD) : 1;
  localparam logic [TW-1:0] TMAX = TW'(SETTLE_CYCLES);

  logic [PW-1:0]  pcnt;
  logic           cs_q, ov_q, uv_q;
  logic [NCH-1:0] short_act, ch_flt, gate_nxt, settled, open_now, short_now, live;

  wire bat_bad  = bat_over | bat_under;
  wire cs_fall  = cs_q & ~cs_n;
  wire retry_on = pcnt < PW'(RETRY_ON);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else if (pcnt == PW'(RETRY_PERIOD - 1)) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= 1'b1;
      ov_q <= 1'b0;
      uv_q <= 1'b0;
    end else begin
      cs_q <= cs_n;
      ov_q <= cs_fall ? bat_over  : (ov_q | bat_over);
      uv_q <= cs_fall ? bat_under : (uv_q | bat_under);
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [TW-1:0] tmr;

    assign gate_nxt[i]  = !bat_bad && cmd_en[i] && (!short_act[i] || (!LATCH_OFF && retry_on));
    assign settled[i]   = (tmr == TMAX);
    assign open_now[i]  = !bat_bad && settled[i] && !gate[i] && !drain_hi[i];
    assign short_now[i] = !bat_bad && settled[i] &&  gate[i] &&  drain_hi[i];
    assign live[i]      = open_now[i] | short_now[i] | short_act[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        tmr          <= '0;
        gate[i]      <= 1'b0;
        short_act[i] <= 1'b0;
        ch_flt[i]    <= 1'b0;
      end else begin
        gate[i] <= gate_nxt[i];
        if (gate_nxt[i] != gate[i]) tmr <= '0;
        else if (tmr != TMAX) tmr <= tmr + 1'b1;
        if (short_now[i]) short_act[i] <= 1'b1;
        else if (!cmd_en[i]) short_act[i] <= 1'b0;
        ch_flt[i] <= cs_fall ? live[i] : (ch_flt[i] | open_now[i] | short_now[i]);
      end

    a_r3_no_flag_before_settle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_flt[i] && !settled[i] && !cs_fall) |=> !ch_flt[i]);

    if (LATCH_OFF) begin : g_latch
      a_r7_latched_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        short_act[i] |=> !gate[i]);
    end
  end

  assign fault_vec = {ov_q, uv_q, ch_flt};
  assign flt_n     = ~|fault_vec;

  a_r9_battery_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    bat_bad |=> (gate == '0));

  a_r6_sticky_without_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> ((fault_vec & $past(fault_vec)) == $past(fault_vec)));

  a_r10_no_channel_flag_in_bat_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_bad && ch_flt == '0 && !cs_fall) |=> (ch_flt == '0));
endmodule

// File: tb/sim_load_fault_supervisor.sv
module sim_load_fault_supervisor;
  localparam int NCH = 6;
  localparam int SET = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] cmd_en = '0;
  logic [NCH-1:0] drain_hi = '1;
  logic bat_over = 1'b0, bat_under = 1'b0, cs_n = 1'b1;
  logic [NCH-1:0] gate0, gate1;
  logic flt0, flt1;
  logic [NCH+1:0] fv0, fv1;

  always #2 clk = ~clk;

  load_fault_supervisor #(.NCH(NCH), .SETTLE_CYCLES(SET), .RETRY_PERIOD(16), .RETRY_ON(1), .LATCH_OFF(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .drain_hi(drain_hi), .bat_over(bat_over),
    .bat_under(bat_under), .cs_n(cs_n), .gate(gate0), .flt_n(flt0), .fault_vec(fv0));

  load_fault_supervisor #(.NCH(NCH), .SETTLE_CYCLES(SET), .RETRY_PERIOD(16), .RETRY_ON(1), .LATCH_OFF(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .drain_hi(drain_hi), .bat_over(bat_over),
    .bat_under(bat_under), .cs_n(cs_n), .gate(gate1), .flt_n(flt1), .fault_vec(fv1));

  typedef struct {
    string tag;
    int    kind;
    int    exp;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0, pwm_cnt = 0;
  bit done = 0;

  task automatic expect_val(string tag, int kind, int exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic expect_all(string tag, int g, int fv, int fl);
    expect_val(tag, 0, g);  expect_val(tag, 1, g);
    expect_val(tag, 2, fv); expect_val(tag, 3, fv);
    expect_val(tag, 4, fl); expect_val(tag, 5, fl);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int observe(int kind);
    case (kind)
      0: return int'(gate0);
      1: return int'(gate1);
      2: return int'(fv0);
      3: return int'(fv1);
      4: return int'(flt0);
      5: return int'(flt1);
      default: return pwm_cnt;
    endcase
  endfunction

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      act = observe(it.kind);
      n_chk++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_all("R1 reset", 0, 0, 1);
    tick(1);
    rst_n = 1'b1;
    drain_hi = 6'b111100;
    cmd_en = 6'b000011;
    tick(1);
    expect_all("R2 gate follows cmd", 3, 0, 1);
    tick(SET + 5);
    expect_all("R2 healthy loads no fault", 3, 0, 1);

    // R3 open load on ch0: gate off, drain low
    cmd_en = 6'b000010;
    tick(SET + 1);
    expect_val("R3 not before settle", 2, 0);
    tick(1);
    expect_all("R3 R5 open flagged", 2, 8'h01, 0);

    // R6 clear with condition present, then after removal
    cs_n = 1'b0; tick(1);
    expect_val("R6 cs keeps live fault", 2, 8'h01);
    cs_n = 1'b1; drain_hi = 6'b111101; tick(3);
    expect_val("R6 sticky after removal", 2, 8'h01);
    expect_val("R5 flt held", 4, 0);
    cs_n = 1'b0; tick(1);
    expect_all("R6 cs clears gone fault", 2, 0, 1);
    cs_n = 1'b1; tick(2);

    // R4 short on ch1
    drain_hi = 6'b111111;
    tick(1);
    expect_val("R4 short flagged u0", 2, 8'h02);
    expect_val("R4 short flagged u1", 3, 8'h02);
    expect_val("R4 flt low", 4, 0);
    tick(2);
    expect_val("R7 latch gate off", 0, 0);
    tick(3);
    pwm_cnt = 0;
    for (int k = 0; k < 32; k++) begin
      if (gate1[1]) pwm_cnt++;
      tick(1);
    end
    expect_val("R8 retry duty 2 of 32", 6, 2);
    tick(10);
    expect_val("R7 latch still off", 0, 0);
    cmd_en = 6'b000000; tick(1);
    cmd_en = 6'b000010; drain_hi = 6'b111101; tick(2);
    expect_all("R7 R8 toggle restores gate", 2, 8'h02, 0);
    tick(SET + 5);
    expect_val("R4 no new short healthy", 0, 2);
    cs_n = 1'b0; tick(1);
    expect_all("R6 short cleared by cs", 2, 0, 1);
    cs_n = 1'b1; tick(2);

    // R9 R10 battery over: ch1 drain low while forced off
    bat_over = 1'b1; tick(1);
    expect_all("R9 over forces off", 0, 8'h80, 0);
    tick(SET + 10);
    expect_all("R10 no open during bat fault", 0, 8'h80, 0);
    bat_over = 1'b0; tick(1);
    expect_val("R9 gates return u0", 0, 2);
    expect_val("R9 gates return u1", 1, 2);
    cs_n = 1'b0; tick(1);
    expect_all("R6 bat cleared", 2, 0, 1);
    cs_n = 1'b1; tick(2);

    bat_under = 1'b1; tick(1);
    expect_all("R9 R5 under flag", 0, 8'h40, 0);
    cs_n = 1'b0; tick(1);
    expect_val("R6 under kept while present", 2, 8'h40);
    cs_n = 1'b1; bat_under = 1'b0; tick(2);
    expect_val("R6 under sticky", 3, 8'h40);
    cs_n = 1'b0; tick(1);
    expect_all("R6 under cleared", 2, 0, 1);
    cs_n = 1'b1; tick(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule